// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps the bookkeeping for a physical register file of `NAREG` entries that software sees through a sliding 16-register window. It holds the current window base, counted in groups of four registers, and a bitmap with one bit per group that marks which call frames are live. A decoder outside the block hands it one windowed operation at a time: call entry, windowed return, explicit rotate, or stack-pointer move. The block checks whether the operation is legal and updates the base and the bitmap. When the operation cannot complete, it raises an exception request with a cause code.

The contents of the register array belong to the surrounding datapath. The block only computes indices and values for it. Two combinational read ports turn logical register numbers into physical indices using the current base. A successful entry produces one write request carrying the new stack value. A successful return produces the return address. Every exception request carries the old base, which goes into the status word, and the PC of the operation.

Operations arrive on a single-cycle strobe `op_valid`. There is no back-pressure: every strobe is consumed on the clock edge that samples it. All results are registered and appear for exactly one cycle after that edge.

Top module: `regwin_ctrl`

## Requirements
- R1: After reset the window base is 0, the live bitmap holds only bit 0 (value 1), and `spw_valid`, `ret_valid` and `exc_valid` are 0.
- R2: Read port i reports physical index (4*base + `rd_lidx[4i+3:4i]`) mod `NAREG`, combinationally from the current base.
- R3: Entry (`op_code`=0) is illegal when `op_sel` > 3, when `ps_woe` is 0, or when `ps_excm` is 1. An illegal entry raises cause 7 and leaves the base and the bitmap unchanged.
- R4: A legal entry overflows when the nearest live frame above the base lies at distance d, with 1 <= d <= `ps_callinc`. The base then advances by d and the bitmap is unchanged. The cause is 1 if the next live frame beyond it lies at distance d+1, 2 if at d+2, and 3 otherwise. No write request is issued.
- R5: A legal entry without overflow advances the base by `ps_callinc` and sets the bitmap bit of the new base. It issues a write request with index 4*(old base + `ps_callinc`) + `op_sel[1:0]` mod `NAREG` and data `op_val` - `op_imm`.
- R6: A return (`op_code`=1) takes n = `op_val[31:30]`. Let m be 1, 2 or 3 for the nearest live frame among the three below the base, or 0 if none of them is live. The return is illegal if n = 0, if m != 0 and m != n, or if `ps_woe` = 0 or `ps_excm` = 1. An illegal return raises cause 7 and changes nothing.
- R7: A legal return whose target frame (base - n) is live moves the base down by n and clears the bitmap bit of the old base. It reports `ret_pc` = {`op_pc[31:30]`, `op_val[29:0]`}.
- R8: A legal return whose target frame is not live moves the base down by n, leaves the bitmap unchanged, and raises cause 4, 5 or 6 for n = 1, 2 or 3.
- R9: A stack-pointer move (`op_code`=3) raises cause 8 when none of the three frames below the base are live. Otherwise it has no effect.
- R10: A rotate (`op_code`=2) adds the sign-extended `op_imm[3:0]` to the base modulo `NAREG`/4 and leaves the bitmap unchanged.
- R11: Results appear in the cycle after the sampling edge and last one cycle. `exc_owb` is the base before the operation and `exc_pc` is `op_pc`. No exception is reported together with a write request or a return. A cycle without `op_valid` changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe, consumed the same cycle |
| op_code | input | 2 | 0 entry, 1 return, 2 rotate, 3 stack-pointer move |
| op_sel | input | 4 | Entry stack register selector |
| op_imm | input | DW | Entry frame size; rotate delta in bits 3:0 |
| op_val | input | DW | Entry: old stack value; return: logical register 0 |
| op_pc | input | DW | PC of the operation |
| ps_woe | input | 1 | Window-overflow enable from the status word |
| ps_excm | input | 1 | Exception mode from the status word |
| ps_callinc | input | 2 | Call increment from the status word |
| rd_lidx | input | N_RD*4 | Logical register numbers for the read ports |
| rd_pidx | output | N_RD*PIW | Physical indices for the read ports |
| win_base | output | WBW | Current window base |
| win_start | output | NW | Live-frame bitmap |
| spw_valid | output | 1 | Stack register write request |
| spw_idx | output | PIW | Physical index of the stack write |
| spw_data | output | DW | New stack value |
| ret_valid | output | 1 | Return completed |
| ret_pc | output | DW | Return address |
| exc_valid | output | 1 | Exception request |
| exc_cause | output | 4 | Cause code (1-3 overflow, 4-6 underflow, 7 illegal, 8 alloca) |
| exc_owb | output | WBW | Base before the operation |
| exc_pc | output | DW | PC of the faulting operation |

## Verification
The hardest situation to reach is a return underflow. It needs a legal return while none of the three frames below the base are live, and ordinary entry/return pairs almost never leave the bitmap in that shape. A directed sequence first rotates the base far away from the only live frame and then enters and returns. The random phase steers most return operands toward the distance the bench model sees, so that long runs of returns drain the bitmap. The same phase fills the bitmap with repeated entries, which forces overflows of all three sizes.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    OP_ENTRY = 2'd0,
    OP_RETW  = 2'd1,
    OP_ROTW  = 2'd2,
    OP_MOVSP = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_OVF4    = 4'd1,
    EXC_OVF8    = 4'd2,
    EXC_OVF12   = 4'd3,
    EXC_UNF4    = 4'd4,
    EXC_UNF8    = 4'd5,
    EXC_UNF12   = 4'd6,
    EXC_ILLEGAL = 4'd7,
    EXC_ALLOCA  = 4'd8
  } exc_e;

endpackage

// File: rtl/regwin_map.sv
module regwin_map #(
  parameter int NAREG = 64,
  parameter int N_RD  = 2,
  localparam int NW   = NAREG / 4,
  localparam int WBW  = $clog2(NW),
  localparam int PIW  = $clog2(NAREG)
) (
  input  logic [WBW-1:0]      base_i,
  input  logic [N_RD*4-1:0]   lidx_i,
  output logic [N_RD*PIW-1:0] pidx_o
);

  for (genvar i = 0; i < N_RD; i++) begin : g_port
    // the physical index wraps naturally at PIW bits
    assign pidx_o[i*PIW +: PIW] = {base_i, 2'b00} + PIW'(lidx_i[i*4 +: 4]);
  end

endmodule

// File: rtl/regwin_scan.sv
module regwin_scan import regwin_pkg::*; #(
  parameter int NW   = 16,
  localparam int WBW = $clog2(NW)
) (
  input  logic [NW-1:0]  ws_i,
  input  logic [WBW-1:0] wb_i,
  input  logic [1:0]     callinc_i,
  output logic           ovf_hit_o,
  output logic [WBW-1:0] ovf_step_o,
  output exc_e           ovf_kind_o,
  output logic [1:0]     below_m_o
);

  // above[k] is the frame at distance k+1 above the base; the last bit is the base itself
  logic [NW-1:0] above;
  for (genvar k = 0; k < NW; k++) begin : g_rot
    logic [WBW-1:0] pos;
    assign pos      = wb_i + WBW'(k + 1);
    assign above[k] = ws_i[pos];
  end

  int   lead_i;
  int   next_d;
  logic lead_ok;

  always_comb begin
    lead_i  = 0;
    lead_ok = 1'b0;
    for (int k = NW - 1; k >= 0; k--) begin
      if (above[k]) begin
        lead_i  = k;
        lead_ok = 1'b1;
      end
    end
    next_d = -1;
    for (int k = NW - 1; k >= 0; k--) begin
      if (above[k] && (k > lead_i)) next_d = k - lead_i - 1;
    end
  end

  assign ovf_hit_o  = lead_ok && (lead_i < int'(callinc_i));
  assign ovf_step_o = WBW'(lead_i + 1);
  assign ovf_kind_o = (next_d == 0) ? EXC_OVF4 : (next_d == 1) ? EXC_OVF8 : EXC_OVF12;

  logic [WBW-1:0] dn1, dn2, dn3;
  assign dn1 = wb_i - WBW'(1);
  assign dn2 = wb_i - WBW'(2);
  assign dn3 = wb_i - WBW'(3);
  assign below_m_o = ws_i[dn1] ? 2'd1 : ws_i[dn2] ? 2'd2 : ws_i[dn3] ? 2'd3 : 2'd0;

endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl import regwin_pkg::*; #(
  parameter int NAREG = 64,
  parameter int N_RD  = 2,
  parameter int DW    = 32,
  localparam int NW   = NAREG / 4,
  localparam int WBW  = $clog2(NW),
  localparam int PIW  = $clog2(NAREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [1:0]          op_code,
  input  logic [3:0]          op_sel,
  input  logic [DW-1:0]       op_imm,
  input  logic [DW-1:0]       op_val,
  input  logic [DW-1:0]       op_pc,
  input  logic                ps_woe,
  input  logic                ps_excm,
  input  logic [1:0]          ps_callinc,
  input  logic [N_RD*4-1:0]   rd_lidx,
  output logic [N_RD*PIW-1:0] rd_pidx,
  output logic [WBW-1:0]      win_base,
  output logic [NW-1:0]       win_start,
  output logic                spw_valid,
  output logic [PIW-1:0]      spw_idx,
  output logic [DW-1:0]       spw_data,
  output logic                ret_valid,
  output logic [DW-1:0]       ret_pc,
  output logic                exc_valid,
  output logic [3:0]          exc_cause,
  output logic [WBW-1:0]      exc_owb,
  output logic [DW-1:0]       exc_pc
);

  logic [WBW-1:0] wb_q;
  logic [NW-1:0]  ws_q;

  logic           ovf_hit;
  logic [WBW-1:0] ovf_step;
  exc_e           ovf_kind;
  logic [1:0]     below_m;

  regwin_scan #(.NW(NW)) u_scan (
    .ws_i       (ws_q),
    .wb_i       (wb_q),
    .callinc_i  (ps_callinc),
    .ovf_hit_o  (ovf_hit),
    .ovf_step_o (ovf_step),
    .ovf_kind_o (ovf_kind),
    .below_m_o  (below_m)
  );

  regwin_map #(.NAREG(NAREG), .N_RD(N_RD)) u_map (
    .base_i (wb_q),
    .lidx_i (rd_lidx),
    .pidx_o (rd_pidx)
  );

  // next-state decision
  logic [WBW-1:0] nx_wb, ent_wb;
  logic [NW-1:0]  nx_ws;
  logic           nx_spw, nx_ret, mode_ok;
  logic [PIW-1:0] nx_spw_idx;
  logic [1:0]     ret_n;
  logic [31:0]    rot_ext;
  exc_e           nx_exc;

  assign mode_ok = ps_woe && !ps_excm;
  assign ent_wb  = wb_q + WBW'(ps_callinc);
  assign ret_n   = op_val[DW-1:DW-2];
  assign rot_ext = {{28{op_imm[3]}}, op_imm[3:0]};

  always_comb begin
    nx_wb      = wb_q;
    nx_ws      = ws_q;
    nx_spw     = 1'b0;
    nx_spw_idx = {ent_wb, op_sel[1:0]};
    nx_ret     = 1'b0;
    nx_exc     = EXC_NONE;
    if (op_valid) begin
      unique case (op_e'(op_code))
        OP_ENTRY: begin
          if (!mode_ok || (op_sel > 4'd3)) begin
            nx_exc = EXC_ILLEGAL;
          end else if (ovf_hit) begin
            nx_wb  = wb_q + ovf_step;
            nx_exc = ovf_kind;
          end else begin
            nx_wb         = ent_wb;
            nx_ws[ent_wb] = 1'b1;
            nx_spw        = 1'b1;
          end
        end
        OP_RETW: begin
          if ((ret_n == 2'd0) || ((below_m != 2'd0) && (below_m != ret_n)) || !mode_ok) begin
            nx_exc = EXC_ILLEGAL;
          end else begin
            nx_wb = wb_q - WBW'(ret_n);
            if (ws_q[nx_wb]) begin
              nx_ws[wb_q] = 1'b0;
              nx_ret      = 1'b1;
            end else begin
              unique case (ret_n)
                2'd1:    nx_exc = EXC_UNF4;
                2'd2:    nx_exc = EXC_UNF8;
                default: nx_exc = EXC_UNF12;
              endcase
            end
          end
        end
        OP_ROTW: nx_wb = wb_q + rot_ext[WBW-1:0];
        OP_MOVSP: if (below_m == 2'd0) nx_exc = EXC_ALLOCA;
        default: ;
      endcase
    end
  end

  exc_e exc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_q      <= '0;
      ws_q      <= NW'(1);
      spw_valid <= 1'b0;
      spw_idx   <= '0;
      spw_data  <= '0;
      ret_valid <= 1'b0;
      ret_pc    <= '0;
      exc_q     <= EXC_NONE;
      exc_owb   <= '0;
      exc_pc    <= '0;
    end else begin
      wb_q      <= nx_wb;
      ws_q      <= nx_ws;
      spw_valid <= nx_spw;
      spw_idx   <= nx_spw_idx;
      spw_data  <= op_val - op_imm;
      ret_valid <= nx_ret;
      ret_pc    <= {op_pc[DW-1:DW-2], op_val[DW-3:0]};
      exc_q     <= nx_exc;
      exc_owb   <= wb_q;
      exc_pc    <= op_pc;
    end
  end

  assign win_base  = wb_q;
  assign win_start = ws_q;
  assign exc_valid = (exc_q != EXC_NONE);
  assign exc_cause = exc_q;

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(wb_q) && $stable(ws_q)));

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!ret_valid && !spw_valid));

  assert_entry_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    spw_valid |-> ws_q[wb_q]);

  assert_ret_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> !ws_q[$past(wb_q)]);

  assert_ovf_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q inside {EXC_OVF4, EXC_OVF8, EXC_OVF12}) |-> ws_q[wb_q]);

  assert_unf_dead_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q inside {EXC_UNF4, EXC_UNF8, EXC_UNF12}) |-> !ws_q[wb_q]);

  assert_illegal_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_q == EXC_ILLEGAL) |-> ($stable(wb_q) && $stable(ws_q)));

endmodule

// File: tb/regwin_ctrl_bench.sv
module regwin_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NAREG = 64;
  localparam int N_RD  = 2;
  localparam int DW    = 32;
  localparam int NW    = NAREG / 4;
  localparam int WBW   = $clog2(NW);
  localparam int PIW   = $clog2(NAREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_code = '0;
  logic [3:0] op_sel = '0;
  logic [DW-1:0] op_imm = '0, op_val = '0, op_pc = '0;
  logic ps_woe = 1'b0, ps_excm = 1'b0;
  logic [1:0] ps_callinc = '0;
  logic [N_RD*4-1:0] rd_lidx = '0;
  logic [N_RD*PIW-1:0] rd_pidx;
  logic [WBW-1:0] win_base;
  logic [NW-1:0] win_start;
  logic spw_valid, ret_valid, exc_valid;
  logic [PIW-1:0] spw_idx;
  logic [DW-1:0] spw_data, ret_pc, exc_pc;
  logic [3:0] exc_cause;
  logic [WBW-1:0] exc_owb;

  regwin_ctrl #(.NAREG(NAREG), .N_RD(N_RD), .DW(DW)) u_regwin_ctrl (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .op_sel(op_sel),
    .op_imm(op_imm), .op_val(op_val), .op_pc(op_pc), .ps_woe(ps_woe), .ps_excm(ps_excm),
    .ps_callinc(ps_callinc), .rd_lidx(rd_lidx), .rd_pidx(rd_pidx), .win_base(win_base),
    .win_start(win_start), .spw_valid(spw_valid), .spw_idx(spw_idx), .spw_data(spw_data),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .exc_valid(exc_valid), .exc_cause(exc_cause),
    .exc_owb(exc_owb), .exc_pc(exc_pc)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // reference model state and expectations
  int m_wb;
  logic [NW-1:0] m_ws;
  logic e_spw, e_ret, e_exc;
  int e_idx, e_cause, e_owb;
  logic [DW-1:0] e_data, e_rpc, e_pc;
  string tag;

  task automatic chk(input string t, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic int below_live();
    if (m_ws[(m_wb + NW - 1) % NW]) return 1;
    if (m_ws[(m_wb + NW - 2) % NW]) return 2;
    if (m_ws[(m_wb + NW - 3) % NW]) return 3;
    return 0;
  endfunction

  task automatic model(input logic [1:0] code, input logic [3:0] sel, input logic [DW-1:0] imm,
                       input logic [DW-1:0] val, input logic [DW-1:0] pc, input logic woe,
                       input logic excm, input logic [1:0] ci);
    int d1, d2, mm, nn, nb, dl;
    logic ok;
    e_spw = 1'b0; e_ret = 1'b0; e_exc = 1'b0; e_cause = 0;
    e_owb = m_wb; e_pc = pc; e_idx = 0; e_data = '0; e_rpc = '0;
    ok = woe && !excm;
    case (code)
      2'd0: begin
        if (!ok || sel > 4'd3) begin
          e_exc = 1'b1; e_cause = 7; tag = "R3";
        end else begin
          d1 = 0;
          for (int k = NW; k >= 1; k--) if (m_ws[(m_wb + k) % NW]) d1 = k;
          if (ci != 2'd0 && d1 >= 1 && d1 <= int'(ci)) begin
            d2 = 0;
            for (int k = NW; k > d1; k--) if (m_ws[(m_wb + k) % NW]) d2 = k;
            e_exc = 1'b1;
            e_cause = (d2 - d1 == 1) ? 1 : (d2 - d1 == 2) ? 2 : 3;
            m_wb = (m_wb + d1) % NW;
            tag = "R4";
          end else begin
            e_spw = 1'b1;
            e_idx = ((m_wb + int'(ci)) * 4 + int'(sel[1:0])) % NAREG;
            e_data = val - imm;
            m_wb = (m_wb + int'(ci)) % NW;
            m_ws[m_wb] = 1'b1;
            tag = "R5";
          end
        end
      end
      2'd1: begin
        nn = int'(val[DW-1:DW-2]);
        mm = below_live();
        if (nn == 0 || (mm != 0 && mm != nn) || !ok) begin
          e_exc = 1'b1; e_cause = 7; tag = "R6";
        end else begin
          nb = (m_wb + NW - nn) % NW;
          if (m_ws[nb]) begin
            m_ws[m_wb] = 1'b0;
            e_ret = 1'b1;
            e_rpc = {pc[DW-1:DW-2], val[DW-3:0]};
            tag = "R7";
          end else begin
            e_exc = 1'b1; e_cause = 3 + nn; tag = "R8";
          end
          m_wb = nb;
        end
      end
      2'd2: begin
        dl = imm[3] ? int'(imm[3:0]) - 16 : int'(imm[3:0]);
        m_wb = ((m_wb + dl) % NW + NW) % NW;
        tag = "R10";
      end
      default: begin
        if (below_live() == 0) begin
          e_exc = 1'b1; e_cause = 8;
        end
        tag = "R9";
      end
    endcase
  endtask

  task automatic check_outputs();
    chk(tag, "base", 64'(win_base), 64'(m_wb));
    chk(tag, "bitmap", 64'(win_start), 64'(m_ws));
    chk(tag, "spw_valid", 64'(spw_valid), 64'(e_spw));
    if (e_spw) begin
      chk(tag, "spw_idx", 64'(spw_idx), 64'(e_idx));
      chk(tag, "spw_data", 64'(spw_data), 64'(e_data));
    end
    chk(tag, "ret_valid", 64'(ret_valid), 64'(e_ret));
    if (e_ret) chk(tag, "ret_pc", 64'(ret_pc), 64'(e_rpc));
    chk(tag, "exc_valid", 64'(exc_valid), 64'(e_exc));
    chk(tag, "exc_cause", 64'(exc_cause), 64'(e_cause));
    if (e_exc) begin
      chk("R11", "exc_owb", 64'(exc_owb), 64'(e_owb));
      chk("R11", "exc_pc", 64'(exc_pc), 64'(e_pc));
    end
  endtask

  task automatic check_map();
    rd_lidx = N_RD*4'($urandom);
    #1;
    for (int i = 0; i < N_RD; i++)
      chk("R2", "rd_pidx", 64'(rd_pidx[i*PIW +: PIW]),
          64'((m_wb * 4 + int'(rd_lidx[i*4 +: 4])) % NAREG));
  endtask

  task automatic do_op(input logic [1:0] code, input logic [3:0] sel, input logic [DW-1:0] imm,
                       input logic [DW-1:0] val, input logic [DW-1:0] pc, input logic woe,
                       input logic excm, input logic [1:0] ci);
    @(negedge clk);
    // idle cycle since the last operation: pulses gone, state held (R11)
    chk("R11", "idle spw", 64'(spw_valid), 64'd0);
    chk("R11", "idle ret", 64'(ret_valid), 64'd0);
    chk("R11", "idle exc", 64'(exc_valid), 64'd0);
    chk("R11", "idle base", 64'(win_base), 64'(m_wb));
    chk("R11", "idle bitmap", 64'(win_start), 64'(m_ws));
    op_code = code; op_sel = sel; op_imm = imm; op_val = val; op_pc = pc;
    ps_woe = woe; ps_excm = excm; ps_callinc = ci; op_valid = 1'b1;
    model(code, sel, imm, val, pc, woe, excm, ci);
    @(negedge clk);
    op_valid = 1'b0;
    check_outputs();
    check_map();
  endtask

  logic done = 1'b0;
  logic [1:0] r_code, r_ci;
  logic [3:0] r_sel;
  logic [DW-1:0] r_val;
  int r, mm;

  initial begin
    void'($urandom(32'h5EED_0042));
    m_wb = 0;
    m_ws = NW'(1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset base", 64'(win_base), 64'd0);
    chk("R1", "reset bitmap", 64'(win_start), 64'd1);
    chk("R1", "reset valids", 64'({spw_valid, ret_valid, exc_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset base", 64'(win_base), 64'd0);
    chk("R1", "post-reset bitmap", 64'(win_start), 64'd1);

    // directed: illegal entries R3
    do_op(2'd0, 4'd5, 32'd16, 32'h1000, 32'h4000_0010, 1'b1, 1'b0, 2'd1);
    do_op(2'd0, 4'd1, 32'd16, 32'h1000, 32'h4000_0014, 1'b0, 1'b0, 2'd1);
    do_op(2'd0, 4'd1, 32'd16, 32'h1000, 32'h4000_0018, 1'b1, 1'b1, 2'd1);
    // directed: fill frames with call increment 3, then overflow R4, R5
    for (int i = 0; i < 6; i++)
      do_op(2'd0, 4'd1, 32'd32, 32'h2000 + i, 32'h8000_0100 + i, 1'b1, 1'b0, 2'd3);
    do_op(2'd0, 4'd1, 32'd32, 32'h2100, 32'h8000_0200, 1'b1, 1'b0, 2'd3);
    // directed: normal return R7 with legal distance, then illegal n=0 R6
    do_op(2'd1, 4'd0, 32'd0, {2'd3, 30'h0ABC}, 32'hC000_0300, 1'b1, 1'b0, 2'd0);
    do_op(2'd1, 4'd0, 32'd0, {2'd0, 30'h0ABC}, 32'hC000_0304, 1'b1, 1'b0, 2'd0);
    // directed: underflow R8 and alloca R9 from a fresh state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_wb = 0; m_ws = NW'(1);
    do_op(2'd2, 4'd0, 32'd7, 32'd0, 32'd0, 1'b1, 1'b0, 2'd0);
    do_op(2'd2, 4'd0, 32'd1, 32'd0, 32'd0, 1'b1, 1'b0, 2'd0);
    do_op(2'd3, 4'd0, 32'd0, 32'd0, 32'h0000_0500, 1'b1, 1'b0, 2'd0);
    do_op(2'd0, 4'd2, 32'd8, 32'h3000, 32'h0000_0504, 1'b1, 1'b0, 2'd1);
    do_op(2'd1, 4'd0, 32'd0, {2'd1, 30'h123}, 32'h4000_0508, 1'b1, 1'b0, 2'd0);
    do_op(2'd2, 4'd0, 32'hF, 32'd0, 32'd0, 1'b1, 1'b0, 2'd0);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      r = int'($urandom % 100);
      r_code = (r < 35) ? 2'd0 : (r < 72) ? 2'd1 : (r < 88) ? 2'd2 : 2'd3;
      r_sel = ($urandom % 8 == 0) ? 4'(4 + $urandom % 12) : 4'($urandom % 4);
      r_ci = ($urandom % 8 == 0) ? 2'd0 : 2'(1 + $urandom % 3);
      r_val = $urandom;
      if (r_code == 2'd1 && ($urandom % 4 != 0)) begin
        mm = below_live();
        r_val[DW-1:DW-2] = (mm != 0) ? 2'(mm) : 2'(1 + $urandom % 3);
      end
      do_op(r_code, r_sel, $urandom % 256, r_val, $urandom, ($urandom % 16) != 0,
            ($urandom % 16) == 0, r_ci);
    end

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule